// File: doc/BRIEF.md
# Pipelined Prime Sieve Array

This block filters a stream of small unsigned integers so that only prime numbers come out. A fixed chain of filter stages passes each word along, one stage per clock. Every stage owns one constant divisor: the first stage uses 2, the next 3, then 5 and 7 for the default four stages. A stage that sees a positive word divisible by its divisor, but not equal to it, flips the word's sign to mark it as composite. Marked words still travel to the end of the chain, so every word spends the same number of cycles in flight. A stage forwards a word that is already negative unchanged.

After the last filter register, a drain removes every word that is not strictly positive. The survivors leave on a valid/ready output stream. Both streams follow the usual rule: a word moves on a clock edge where valid and ready are both high. The whole chain advances as one. It steps whenever the output is empty or the consumer is ready. While a surviving word waits on a low `out_ready`, the chain freezes and `in_ready` goes low. A marked word or a bubble in the last stage never blocks the chain.

Top module: `sieve_array`

## Requirements
- R1: With the default four stages (divisors 2, 3, 5, 7 in that order), an input value v in 2..120 leaves the block exactly when v is prime. Surviving values keep their input order.
- R2: A composite value whose factors include 2, 3, 5 or 7 (for example 4, 9, 25, 49) is never presented on the output.
- R3: A value equal to one of the stage divisors (2, 3, 5, 7) is presented on the output unchanged.
- R4: A word marked negative by an earlier stage passes later stages unchanged. This holds even when a later divisor also divides it, so 10, 15, 35, 70 and 105 are all dropped.
- R5: A value whose smallest factor is above the last divisor leaves the block, for example 11, 13, 121, 143 and 169.
- R6: Input 0 is dropped, because the drain only emits strictly positive words. Input 1 leaves the block as 1.
- R7: When `out_ready` stays high, a word accepted on clock edge k appears on `out_valid`/`out_data` after edge k+P-1, where P is the number of stages.
- R8: When `out_ready` stays high, `in_ready` stays high and one word is accepted every cycle. Feeding 2..10 back to back gives 2, 3, 5, 7.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values into the next cycle.
- R10: A cycle with `in_valid` low inserts a bubble that produces no output. After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Chain accepts a word this cycle |
| in_data | input | DATA_W | Unsigned integer to classify |
| out_valid | output | 1 | A surviving (prime) word is presented |
| out_ready | input | 1 | Consumer takes the presented word |
| out_data | output | DATA_W | Surviving value |

## Verification
The bench sends multiples of two divisors, such as 10, 35 and 105. A stage that re-negated a marked word would turn it positive again, and it would leak out as a false prime. It also sends the divisors themselves, which a missing equality guard would drop. It sends 0, which a drain testing only the sign bit would let through. It sends squares of larger primes, which a design claiming more than its divisors allow might drop. Random back-pressure mixed with input bubbles probes whether a frozen output changes value, whether a blocked chain still swallows input, and whether a marked word in the last stage stalls the chain for no reason.

// File: rtl/sieve_pkg.sv
package sieve_pkg;

  // Returns the prime with zero-based index idx (0 -> 2, 1 -> 3, ...).
  function automatic int nth_prime(input int idx);
    int found;
    bit is_p;
    found = 0;
    for (int n = 2; n < 4096; n++) begin
      is_p = 1'b1;
      for (int d = 2; d * d <= n; d++) begin
        if (n % d == 0) is_p = 1'b0;
      end
      if (is_p) begin
        if (found == idx) return n;
        found++;
      end
    end
    return 2;
  endfunction

endpackage

// File: rtl/sieve_filter_stage.sv
module sieve_filter_stage #(
  parameter int WORD_W = 9,
  parameter int PRIME  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic                     in_valid,
  input  logic signed [WORD_W-1:0] in_word,
  output logic                     out_valid,
  output logic signed [WORD_W-1:0] out_word
);

  localparam int MAG_W = WORD_W - 1;
  localparam logic [MAG_W-1:0] DIVISOR = MAG_W'(PRIME);

  logic [MAG_W-1:0]         mag;
  logic                     is_positive;
  logic                     divisible;
  logic                     is_self;
  logic                     mark;
  logic signed [WORD_W-1:0] next_word;

  always_comb begin
    mag         = in_word[MAG_W-1:0];
    is_positive = !in_word[WORD_W-1] && (mag != '0);
    divisible   = (mag % DIVISOR) == '0;
    is_self     = (mag == DIVISOR);
    mark        = is_positive && divisible && !is_self;
    next_word   = mark ? -in_word : in_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (step) begin
      out_valid <= in_valid;
      out_word  <= next_word;
    end
  end

  AST_MARK_NEGATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_valid && !in_word[WORD_W-1] && (in_word[MAG_W-1:0] != '0) &&
     ((in_word[MAG_W-1:0] % DIVISOR) == '0) && (in_word[MAG_W-1:0] != DIVISOR))
    |=> (out_word == -$past(in_word)));  // R2

  AST_DIVISOR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_valid && (in_word == WORD_W'(PRIME))) |=> (out_word == WORD_W'(PRIME)));  // R3

  AST_MARKED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_valid && in_word[WORD_W-1]) |=> (out_word == $past(in_word)));  // R4

  AST_FREEZE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(out_valid) && $stable(out_word)));  // R9

  AST_VALID_TRAVELS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (out_valid == $past(in_valid)));  // R10

endmodule

// File: rtl/sieve_drain.sv
module sieve_drain #(
  parameter int WORD_W = 9,
  parameter int OUT_W  = 8
) (
  input  logic                     in_valid,
  input  logic signed [WORD_W-1:0] in_word,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_data
);

  logic keep;

  always_comb begin
    keep      = !in_word[WORD_W-1] && (in_word[WORD_W-2:0] != '0);
    out_valid = in_valid && keep;
    out_data  = in_word[OUT_W-1:0];
  end

endmodule

// File: rtl/sieve_array.sv
module sieve_array #(
  parameter int DATA_W = 8,
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int WORD_W = DATA_W + 1;

  logic                     chain_valid [STAGES+1];
  logic signed [WORD_W-1:0] chain_word  [STAGES+1];
  logic                     advance;

  assign advance        = out_ready || !out_valid;
  assign in_ready       = advance;
  assign chain_valid[0] = in_valid;
  assign chain_word[0]  = $signed({1'b0, in_data});

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    sieve_filter_stage #(
      .WORD_W (WORD_W),
      .PRIME  (sieve_pkg::nth_prime(g))
    ) stage_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (advance),
      .in_valid  (chain_valid[g]),
      .in_word   (chain_word[g]),
      .out_valid (chain_valid[g+1]),
      .out_word  (chain_word[g+1])
    );
  end

  sieve_drain #(
    .WORD_W (WORD_W),
    .OUT_W  (DATA_W)
  ) drain_i (
    .in_valid  (chain_valid[STAGES]),
    .in_word   (chain_word[STAGES]),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R9

  AST_NO_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data != '0));  // R6

endmodule

// File: tb/sieve_array_tb_top.sv
`timescale 1ns/1ps
module sieve_array_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int STAGES     = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    finished = 1'b0;
  bit    stall_mode = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sieve_array #(.DATA_W(8), .STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic bit survives(input int v);
    int divs[4] = '{2, 3, 5, 7};
    if (v == 0) return 1'b0;
    foreach (divs[i]) if ((v % divs[i] == 0) && (v != divs[i])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Driver: present v, wait for acceptance, push expectation.
  task automatic send(input int v, input string tag, output int waits);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'(v);
    waits = 0;
    forever begin
      #8;
      if (in_ready) break;
      waits++;
      @(negedge clk);
    end
    if (survives(v)) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic bubble();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Back-pressure pattern.
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall_mode ? lfsr[0] : 1'b1;
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit   prev_hold = 1'b0;
    logic [7:0] prev_data = '0;
    forever begin
      @(negedge clk);
      #8;
      if (rst_n === 1'b1) begin
        check(in_ready == (out_ready || !out_valid), "R9 in_ready rule", in_ready,
              out_ready || !out_valid);
        if (prev_hold) begin
          check(out_valid == 1'b1, "R9 valid held", out_valid, 1);
          check(out_data == prev_data, "R9 data held", out_data, prev_data);
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected output", out_data, -1);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == 8'(e), t, out_data, e);
          end
        end
        prev_hold = out_valid && !out_ready;
        prev_data = out_data;
      end
    end
  end

  // Watchdog.
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    int c0;
    int lat_c;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    #8;
    check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 latency of a single word.
    in_valid = 1'b1;
    in_data = 8'd7;
    #8;
    c0 = cyc;
    exp_q.push_back(7);
    tag_q.push_back("R7 value");
    @(negedge clk);
    in_valid = 1'b0;
    lat_c = -1;
    for (int i = 0; i < 20; i++) begin
      #8;
      if (out_valid) begin lat_c = cyc; break; end
      @(negedge clk);
    end
    check(lat_c - c0 == STAGES, "R7 latency", lat_c - c0, STAGES);
    repeat (3) bubble();

    // R8 back-to-back 2..10.
    for (int v = 2; v <= 10; v++) begin
      send(v, "R8 stream", w);
      check(w == 0, "R8 no wait", w, 0);
    end
    repeat (6) bubble();

    // Corner values.
    send(0, "R6", w);   send(1, "R6 one", w);
    send(2, "R3", w);   send(3, "R3", w);  send(5, "R3", w);  send(7, "R3", w);
    send(10, "R4", w);  send(15, "R4", w); send(35, "R4", w);
    send(70, "R4", w);  send(105, "R4", w);
    send(4, "R2", w);   send(9, "R2", w);  send(25, "R2", w); send(49, "R2", w);
    send(11, "R5", w);  send(13, "R5", w); send(121, "R5", w);
    send(143, "R5", w); send(169, "R5", w);
    send(113, "R1", w);
    repeat (6) bubble();

    // Random back-pressure with bubbles, full range.
    stall_mode = 1'b1;
    for (int v = 0; v < 256; v++) begin
      send(v, (v <= 120) ? "R1 sweep" : "R5 sweep", w);
      if (v % 3 == 2) bubble();
    end
    bubble();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    stall_mode = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R10 all drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule